// File: doc/BRIEF.md
# Change-Detection Interrupt Controller

This block samples a set of 8-bit digital input ports, looks for transitions on them and gives the host one level-sensitive interrupt line. Software chooses, for each channel, whether a rising transition, a falling transition, or both may raise an event. Global control bits can switch off all rising detection, all falling detection, or all detection at once.

When an enabled transition is seen, a sticky pending flag is set, together with a flag that records the direction. If another enabled transition arrives while the pending flag is still set, an overflow flag can also be latched. The host reads a status byte over a simple byte-wide register bus and clears the sticky flags by writing ones to a clear register. Each input passes through a two-flop synchroniser before it is compared with its previous sample.

Top module: `chg_irq_ctrl`

## Requirements
- R1: After reset, irq_o is low. The control register, the status register and every per-port enable register read 0.
- R2: Address map (6-bit address): control at 0x00, status at 0x01 (read only), clear at 0x02 (write only), rising-enable register of port p at 0x20+p, falling-enable register of port p at 0x30+p. Control holds 5 bits, and bits 7:5 read as 0. Read data appears on reg_rdata_o in the cycle after reg_re_i and holds until the next read.
- R3: Control bits are: bit0 detection enable, bit1 overflow enable, bit2 interrupt enable, bit3 global rising enable, bit4 global falling enable. With bit0 and bit3 set, a 0-to-1 change on channel 8*p+n whose rising-enable bit n of port p is set sets status bit0 (event pending) and status bit3 (rising seen). Both are visible three clock edges after the input change.
- R4: With bit0 and bit4 set, a 1-to-0 change on a channel whose falling-enable bit is set sets status bit0 and status bit4 (falling seen).
- R5: A transition produces no event if its direction is not enabled for that channel, or if the matching global direction bit is clear, or if control bit0 is clear. A transition on any other channel also produces no event.
- R6: When an enabled transition occurs while event pending is already set and control bit1 is 1, status bit1 (overflow) is set. With control bit1 at 0, no overflow is latched.
- R7: Writing 1 to clear bit3 clears status bits 0, 3 and 4. Writing 1 to clear bit2 clears status bit1. Clear bits written as 0 have no effect.
- R8: If a clear of the pending event arrives in the same cycle as a new enabled transition, the transition wins and event pending stays set.
- R9: irq_o = control bit2 AND (event pending OR (overflow AND control bit1)). Status bit2 reads back the value of irq_o.
- R10: Writing 0 to the control register drops irq_o in the next cycle. While control is 0, no new event is latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_i | input | 8*NUM_PORTS | Raw digital inputs, channel 8*p+n at bit 8*p+n |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe |
| reg_addr_i | input | 6 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, one cycle after the read strobe |
| irq_o | output | 1 | Level interrupt to the host |

## Verification
The bench builds the block with NUM_PORTS = 2, which gives 16 channels. At that size every channel can be swept in both directions, with its own mask bit set and with a neighbour toggling, so a wrong shift in the per-port enable decode shows up. The small map also makes it cheap to walk every combination of the global enables, the overflow enable and the interrupt enable. The clear-versus-edge collision is driven at the exact cycle the synchroniser delivers the edge.

// File: rtl/chg_irq_pkg.sv
`timescale 1ns/1ps
package chg_irq_pkg;
  localparam int REG_ADDR_W = 6;
  localparam int PORT_W     = 8;

  localparam logic [REG_ADDR_W-1:0] ADR_CTRL      = 6'h00;
  localparam logic [REG_ADDR_W-1:0] ADR_STAT      = 6'h01;
  localparam logic [REG_ADDR_W-1:0] ADR_CLR       = 6'h02;
  localparam logic [REG_ADDR_W-1:0] ADR_RISE_BASE = 6'h20;
  localparam logic [REG_ADDR_W-1:0] ADR_FALL_BASE = 6'h30;

  localparam int CTRL_W = 5;

  typedef struct packed {
    logic fall_glb;
    logic rise_glb;
    logic int_en;
    logic ovf_en;
    logic det_en;
  } ctrl_t;

  localparam int CLR_OVF_BIT  = 2;
  localparam int CLR_PEND_BIT = 3;
endpackage

// File: rtl/chg_irq_sync.sv
`timescale 1ns/1ps
module chg_irq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/chg_irq_edge.sv
`timescale 1ns/1ps
module chg_irq_edge #(
  parameter int NUM_PORTS = 4,
  localparam int NCH      = NUM_PORTS * chg_irq_pkg::PORT_W
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] smp_i,
  input  logic [NCH-1:0] rise_en_i,
  input  logic [NCH-1:0] fall_en_i,
  input  logic           det_en_i,
  input  logic           rise_glb_i,
  input  logic           fall_glb_i,
  output logic           rise_any_o,
  output logic           fall_any_o
);
  import chg_irq_pkg::*;

  logic [NCH-1:0] prev_q;
  logic [NUM_PORTS-1:0] port_rise, port_fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= smp_i;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] cur, old;
    assign cur = smp_i[p*PORT_W +: PORT_W];
    assign old = prev_q[p*PORT_W +: PORT_W];
    assign port_rise[p] = |(cur & ~old & rise_en_i[p*PORT_W +: PORT_W]);
    assign port_fall[p] = |(~cur & old & fall_en_i[p*PORT_W +: PORT_W]);
  end

  assign rise_any_o = det_en_i & rise_glb_i & (|port_rise);
  assign fall_any_o = det_en_i & fall_glb_i & (|port_fall);
endmodule

// File: rtl/chg_irq_event.sv
`timescale 1ns/1ps
module chg_irq_event (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rise_any_i,
  input  logic fall_any_i,
  input  logic ovf_en_i,
  input  logic clr_pend_i,
  input  logic clr_ovf_i,
  output logic any_edge_o,
  output logic edge_pend_o,
  output logic ovf_pend_o,
  output logic rise_seen_o,
  output logic fall_seen_o
);
  logic pend_q, ovf_q, rise_q, fall_q;

  assign any_edge_o = rise_any_i | fall_any_i;

  // a new edge outranks a clear issued in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      ovf_q  <= 1'b0;
      rise_q <= 1'b0;
      fall_q <= 1'b0;
    end else begin
      if (any_edge_o)      pend_q <= 1'b1;
      else if (clr_pend_i) pend_q <= 1'b0;

      if (any_edge_o && pend_q && ovf_en_i) ovf_q <= 1'b1;
      else if (clr_ovf_i)                   ovf_q <= 1'b0;

      if (rise_any_i)      rise_q <= 1'b1;
      else if (clr_pend_i) rise_q <= 1'b0;

      if (fall_any_i)      fall_q <= 1'b1;
      else if (clr_pend_i) fall_q <= 1'b0;
    end
  end

  assign edge_pend_o = pend_q;
  assign ovf_pend_o  = ovf_q;
  assign rise_seen_o = rise_q;
  assign fall_seen_o = fall_q;
endmodule

// File: rtl/chg_irq_regs.sv
`timescale 1ns/1ps
module chg_irq_regs #(
  parameter int NUM_PORTS = 4,
  localparam int NCH      = NUM_PORTS * chg_irq_pkg::PORT_W
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               reg_we_i,
  input  logic                               reg_re_i,
  input  logic [chg_irq_pkg::REG_ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]                         reg_wdata_i,
  output logic [7:0]                         reg_rdata_o,
  input  logic [4:0]                         status_i,
  output chg_irq_pkg::ctrl_t                 ctrl_o,
  output logic [NCH-1:0]                     rise_en_o,
  output logic [NCH-1:0]                     fall_en_o,
  output logic                               clr_pend_o,
  output logic                               clr_ovf_o
);
  import chg_irq_pkg::*;

  ctrl_t          ctrl_q;
  logic [NCH-1:0] rise_q, fall_q;
  logic [7:0]     rd_mux, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (reg_we_i) begin
      if (reg_addr_i == ADR_CTRL) ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (reg_addr_i == ADR_RISE_BASE + REG_ADDR_W'(p)) rise_q[p*PORT_W +: PORT_W] <= reg_wdata_i;
        if (reg_addr_i == ADR_FALL_BASE + REG_ADDR_W'(p)) fall_q[p*PORT_W +: PORT_W] <= reg_wdata_i;
      end
    end
  end

  assign clr_pend_o = reg_we_i && (reg_addr_i == ADR_CLR) && reg_wdata_i[CLR_PEND_BIT];
  assign clr_ovf_o  = reg_we_i && (reg_addr_i == ADR_CLR) && reg_wdata_i[CLR_OVF_BIT];

  always_comb begin
    rd_mux = '0;
    if (reg_addr_i == ADR_CTRL) rd_mux = {3'b000, ctrl_q};
    if (reg_addr_i == ADR_STAT) rd_mux = {3'b000, status_i};
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (reg_addr_i == ADR_RISE_BASE + REG_ADDR_W'(p)) rd_mux = rise_q[p*PORT_W +: PORT_W];
      if (reg_addr_i == ADR_FALL_BASE + REG_ADDR_W'(p)) rd_mux = fall_q[p*PORT_W +: PORT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (reg_re_i) rdata_q <= rd_mux;
  end

  assign reg_rdata_o = rdata_q;
  assign ctrl_o      = ctrl_q;
  assign rise_en_o   = rise_q;
  assign fall_en_o   = fall_q;
endmodule

// File: rtl/chg_irq_ctrl.sv
`timescale 1ns/1ps
module chg_irq_ctrl #(
  parameter int NUM_PORTS = 4,
  localparam int NCH      = NUM_PORTS * chg_irq_pkg::PORT_W
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NCH-1:0]                     port_i,
  input  logic                               reg_we_i,
  input  logic                               reg_re_i,
  input  logic [chg_irq_pkg::REG_ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]                         reg_wdata_i,
  output logic [7:0]                         reg_rdata_o,
  output logic                               irq_o
);
  import chg_irq_pkg::*;

  logic [NCH-1:0] smp, rise_en, fall_en;
  ctrl_t          ctrl;
  logic           rise_any, fall_any, any_edge;
  logic           clr_pend, clr_ovf;
  logic           edge_pend, ovf_pend, rise_seen, fall_seen;
  logic [4:0]     status;

  chg_irq_sync #(.WIDTH(NCH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (port_i),
    .q_o   (smp)
  );

  chg_irq_edge #(.NUM_PORTS(NUM_PORTS)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .smp_i     (smp),
    .rise_en_i (rise_en),
    .fall_en_i (fall_en),
    .det_en_i  (ctrl.det_en),
    .rise_glb_i(ctrl.rise_glb),
    .fall_glb_i(ctrl.fall_glb),
    .rise_any_o(rise_any),
    .fall_any_o(fall_any)
  );

  chg_irq_event u_event (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rise_any_i (rise_any),
    .fall_any_i (fall_any),
    .ovf_en_i   (ctrl.ovf_en),
    .clr_pend_i (clr_pend),
    .clr_ovf_i  (clr_ovf),
    .any_edge_o (any_edge),
    .edge_pend_o(edge_pend),
    .ovf_pend_o (ovf_pend),
    .rise_seen_o(rise_seen),
    .fall_seen_o(fall_seen)
  );

  assign irq_o  = ctrl.int_en & (edge_pend | (ovf_pend & ctrl.ovf_en));
  assign status = {fall_seen, rise_seen, irq_o, ovf_pend, edge_pend};

  chg_irq_regs #(.NUM_PORTS(NUM_PORTS)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_we_i   (reg_we_i),
    .reg_re_i   (reg_re_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .status_i   (status),
    .ctrl_o     (ctrl),
    .rise_en_o  (rise_en),
    .fall_en_o  (fall_en),
    .clr_pend_o (clr_pend),
    .clr_ovf_o  (clr_ovf)
  );
endmodule

// File: rtl/chg_irq_ctrl_chk.sv
`timescale 1ns/1ps
module chg_irq_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic       reg_re_i,
  input logic [5:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       irq_o,
  input logic       any_edge_i,
  input logic       edge_pend_i,
  input logic       ovf_pend_i,
  input logic       ovf_en_i
);
  import chg_irq_pkg::*;

  AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_re_i |=> $stable(reg_rdata_o)); // R2

  AST_OVF_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_pend_i) |-> $past(edge_pend_i)); // R6

  AST_OVF_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovf_pend_i) |-> $past(ovf_en_i)); // R6

  AST_ZERO_CLR_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADR_CLR && !reg_wdata_i[CLR_PEND_BIT] && edge_pend_i)
    |=> edge_pend_i); // R7

  AST_NEW_EDGE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_edge_i |=> edge_pend_i); // R8

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (edge_pend_i || ovf_pend_i)); // R9

  AST_CTRL_ZERO_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADR_CTRL && reg_wdata_i == 8'h00) |=> !irq_o); // R10
endmodule

bind chg_irq_ctrl chg_irq_ctrl_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_re_i   (reg_re_i),
  .reg_addr_i (reg_addr_i),
  .reg_wdata_i(reg_wdata_i),
  .reg_rdata_o(reg_rdata_o),
  .irq_o      (irq_o),
  .any_edge_i (any_edge),
  .edge_pend_i(edge_pend),
  .ovf_pend_i (ovf_pend),
  .ovf_en_i   (ctrl.ovf_en)
);

// File: tb/tb_chg_irq_ctrl.sv
`timescale 1ns/1ps
module tb_chg_irq_ctrl;
  localparam int NP  = 2;
  localparam int NCH = NP * 8;
  localparam logic [5:0] A_CTRL = 6'h00, A_STAT = 6'h01, A_CLR = 6'h02;
  localparam logic [5:0] A_RISE = 6'h20, A_FALL = 6'h30;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [NCH-1:0] port_v = '0;
  logic           we = 1'b0, re = 1'b0;
  logic [5:0]     addr = '0;
  logic [7:0]     wdata = '0;
  logic [7:0]     rdata;
  logic           irq;
  int             checks = 0, errors = 0;
  bit             done = 1'b0;

  always #2 clk = ~clk;

  chg_irq_ctrl #(.NUM_PORTS(NP)) dut (
    .clk_i(clk), .rst_ni(rst_n), .port_i(port_v),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [7:0] exp);
    @(negedge clk); re = 1'b1; addr = a;
    @(negedge clk); re = 1'b0;
    chk(req, rdata, exp);
  endtask

  task automatic setp(input int b, input logic v);
    @(negedge clk); port_v[b] = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(A_CTRL, 8'h00);
    @(negedge clk); port_v = '0;
    repeat (3) @(negedge clk);
    wr(A_CLR, 8'h0C);
    for (int p = 0; p < NP; p++) begin
      wr(A_RISE + 6'(p), 8'h00);
      wr(A_FALL + 6'(p), 8'h00);
    end
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq", {7'b0, irq}, 8'h00);
    rd_chk("R1 ctrl", A_CTRL, 8'h00);
    rd_chk("R1 status", A_STAT, 8'h00);
    for (int p = 0; p < NP; p++) begin
      rd_chk("R1 rise_en", A_RISE + 6'(p), 8'h00);
      rd_chk("R1 fall_en", A_FALL + 6'(p), 8'h00);
    end

    // R2 register access
    wr(A_CTRL, 8'hFF);
    rd_chk("R2 ctrl width", A_CTRL, 8'h1F);
    wr(A_CTRL, 8'h00);
    for (int p = 0; p < NP; p++) begin
      wr(A_RISE + 6'(p), 8'(8'hA5 ^ (p * 8'h3C)));
      wr(A_FALL + 6'(p), 8'(8'h5A ^ (p * 8'h71)));
    end
    for (int p = 0; p < NP; p++) begin
      rd_chk("R2 rise_en", A_RISE + 6'(p), 8'(8'hA5 ^ (p * 8'h3C)));
      rd_chk("R2 fall_en", A_FALL + 6'(p), 8'(8'h5A ^ (p * 8'h71)));
    end
    quiesce();

    // Per-channel sweep: R3 R4 R5 R7
    for (int c = 0; c < NCH; c++) begin
      automatic int p = c / 8;
      automatic logic [7:0] m = 8'(1 << (c % 8));
      automatic int n = (c + 1) % NCH;
      wr(A_CTRL, 8'h19);
      wr(A_RISE + 6'(p), m);
      setp(c, 1'b1);
      rd_chk("R3 rise event", A_STAT, 8'h09);
      wr(A_CLR, 8'h08);
      rd_chk("R7 clear pend", A_STAT, 8'h00);
      setp(c, 1'b0);
      rd_chk("R5 fall not enabled", A_STAT, 8'h00);
      wr(A_RISE + 6'(p), 8'h00);
      wr(A_FALL + 6'(p), m);
      setp(c, 1'b1);
      rd_chk("R5 rise not enabled", A_STAT, 8'h00);
      setp(c, 1'b0);
      rd_chk("R4 fall event", A_STAT, 8'h11);
      wr(A_CLR, 8'h08);
      setp(n, 1'b1);
      setp(n, 1'b0);
      rd_chk("R5 other channel", A_STAT, 8'h00);
      wr(A_FALL + 6'(p), 8'h00);
    end
    quiesce();

    // R5 global gating
    for (int p = 0; p < NP; p++) begin
      wr(A_RISE + 6'(p), 8'hFF);
      wr(A_FALL + 6'(p), 8'hFF);
    end
    wr(A_CTRL, 8'h11);
    setp(0, 1'b1);
    rd_chk("R5 global rise off", A_STAT, 8'h00);
    wr(A_CTRL, 8'h09);
    setp(0, 1'b0);
    rd_chk("R5 global fall off", A_STAT, 8'h00);
    wr(A_CTRL, 8'h18);
    setp(3, 1'b1);
    setp(3, 1'b0);
    rd_chk("R5 detect off", A_STAT, 8'h00);

    // R6 overflow, R7 zero-write and separate clears
    wr(A_CTRL, 8'h1B);
    setp(0, 1'b1);
    rd_chk("R6 first edge", A_STAT, 8'h09);
    setp(1, 1'b1);
    rd_chk("R6 overflow", A_STAT, 8'h0B);
    wr(A_CLR, 8'h00);
    rd_chk("R7 zero write", A_STAT, 8'h0B);
    wr(A_CLR, 8'h04);
    rd_chk("R7 clear ovf only", A_STAT, 8'h09);
    wr(A_CLR, 8'h08);
    rd_chk("R7 clear pend", A_STAT, 8'h00);
    wr(A_CTRL, 8'h19);
    setp(0, 1'b0);
    setp(1, 1'b0);
    rd_chk("R6 no ovf when disabled", A_STAT, 8'h11);
    wr(A_CLR, 8'h08);

    // R9 interrupt composition
    wr(A_CTRL, 8'h1D);
    chk("R9 idle irq", {7'b0, irq}, 8'h00);
    setp(2, 1'b1);
    chk("R9 irq on pend", {7'b0, irq}, 8'h01);
    rd_chk("R9 status int", A_STAT, 8'h0D);
    wr(A_CLR, 8'h08);
    chk("R9 irq cleared", {7'b0, irq}, 8'h00);
    wr(A_CTRL, 8'h1F);
    setp(2, 1'b0);
    setp(4, 1'b1);
    rd_chk("R9 pend+ovf", A_STAT, 8'h1F);
    wr(A_CLR, 8'h08);
    chk("R9 irq on ovf", {7'b0, irq}, 8'h01);
    rd_chk("R9 ovf only", A_STAT, 8'h06);
    wr(A_CTRL, 8'h1D);
    chk("R9 ovf masked", {7'b0, irq}, 8'h00);
    rd_chk("R9 ovf held", A_STAT, 8'h02);
    wr(A_CLR, 8'h04);

    // R10 control zero
    setp(4, 1'b0);
    chk("R10 irq before", {7'b0, irq}, 8'h01);
    wr(A_CTRL, 8'h00);
    chk("R10 irq dropped", {7'b0, irq}, 8'h00);
    rd_chk("R10 pend kept", A_STAT, 8'h11);
    wr(A_CLR, 8'h08);
    setp(5, 1'b1);
    setp(5, 1'b0);
    rd_chk("R10 no event", A_STAT, 8'h00);
    chk("R10 irq low", {7'b0, irq}, 8'h00);
    quiesce();

    // R8 clear collides with new edge
    wr(A_RISE, 8'hFF);
    wr(A_CTRL, 8'h19);
    setp(0, 1'b1);
    @(negedge clk); port_v[1] = 1'b1;
    @(negedge clk);
    @(negedge clk); we = 1'b1; addr = A_CLR; wdata = 8'h08;
    @(negedge clk); we = 1'b0;
    rd_chk("R8 edge beats clear", A_STAT, 8'h09);
    wr(A_CLR, 8'h08);
    rd_chk("R8 later clear works", A_STAT, 8'h00);
    quiesce();

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule